// File: doc/BRIEF.md
# Flash Program and Chip-Erase Sequencer

This block runs the self-timed write algorithms of a flash-style memory against a small register-modelled cell array. The command decoder in front of it passes on two kinds of start pulse: a single-location program, which carries an address and a data word, and a whole-array erase. The block then works through the operation over a number of clock cycles set by parameters. While it does so, `busy` stays high and the decoder must not issue new commands.

While the block is busy, a read on the data port does not return array contents. It returns a polling status word:
- The top bit is the complement of the top bit being programmed, or 0 during an erase.
- The bit two places below the top is a timeout flag.
- All other bits are zero.

Programming can only clear bits. The stored word becomes the old word ANDed with the new one. If the result does not match the requested data, the block keeps trying until a cycle limit runs out. It then raises the timeout flag and holds the status until a clear command arrives.

An erase first writes zero to every location, one address per cycle in ascending order. After a fixed settle period it sets every location to all ones. A synchronous hardware reset aborts any operation. When the reset arrives during a program, the target cell is left with a defined damaged value.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, `busy` is 0 and reads return the stored word of `rd_addr`.
- R2: An accepted program stores old AND new at the target address and holds `busy` high for exactly PROG_CYCLES cycles when the result equals the new data. Locations may be programmed in any order.
- R3: While a program is running, `rd_data` for any address has bit DATA_W-1 equal to the inverse of bit DATA_W-1 of the programmed data, and all other bits 0 until a timeout.
- R4: If old AND new differs from new, `busy` stays high. After TMO_LIMIT cycles, bit DATA_W-3 of the status reads 1, and bit DATA_W-1 still shows the inverted data bit.
- R5: The timeout status remains until `clr_cmd` is pulsed. The block then returns to read mode, and the location holds old AND new, so a bit that was asked to go from 0 to 1 still reads 0.
- R6: While `busy` is high, `start_prog`, `start_erase` and `clr_cmd` have no effect on the array or on the operation length. When both starts arrive together in read mode, the program wins.
- R7: An erase holds `busy` high for 2^ADDR_W + ERASE_CYCLES cycles. During that time every status read is all zeros. Afterwards every location reads all ones.
- R8: An erase zeroes addresses in ascending order, one per cycle, before any location becomes all ones. A reset during the walk leaves the walked addresses at zero and the rest unchanged. A reset after the walk leaves the whole array at zero.
- R9: A reset while programming ends the operation. The target then holds (old AND new) with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset, aborts any operation |
| start_prog | input | 1 | Pulse: program `op_data` at `op_addr` |
| start_erase | input | 1 | Pulse: erase the whole array |
| op_addr | input | ADDR_W | Program target address |
| op_data | input | DATA_W | Program data |
| clr_cmd | input | 1 | Read/reset command, leaves the timeout state |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array word when idle, status word when busy |
| busy | output | 1 | Operation in progress |

## Verification
A wrong state register shows up at the ports as soon as the next read: the status word carries the wrong polling bit, or `busy` lasts a different number of cycles than the parameters give. A wrong merge or a wrong write address only shows once the block is back in read mode, and only at the affected location. For that reason, every operation is followed by array reads, and these include addresses the operation should not touch. A wrong erase order or a wrong abort handling only shows after a reset in mid-erase. The bench therefore cuts an erase both during the zeroing walk and after it.

// File: rtl/fos_pkg.sv
package fos_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PROG = 3'd1,
    ST_PRE  = 3'd2,
    ST_ERS  = 3'd3,
    ST_FAIL = 3'd4
  } fos_state_e;
endpackage

// File: rtl/fos_step_counter.sv
module fos_step_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (clr)             cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fos_cell_array.sv
module fos_cell_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // cells keep their content across reset, like nonvolatile storage
  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign rd_word  = cells[rd_addr];
  assign tgt_word = cells[tgt_addr];
endmodule

// File: rtl/fos_poll_mux.sv
module fos_poll_mux #(
  parameter int DATA_W = 8
) (
  input  logic              show_status,
  input  logic              op_is_prog,
  input  logic              tmo,
  input  logic              tgt_msb,
  input  logic [DATA_W-1:0] cell_word,
  output logic [DATA_W-1:0] rd_data
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TMO_BIT  = DATA_W - 3;

  function automatic logic [DATA_W-1:0] poll_word(input logic prog, input logic msb,
                                                  input logic t);
    logic [DATA_W-1:0] w;
    w           = '0;
    w[POLL_BIT] = prog ? ~msb : 1'b0;
    w[TMO_BIT]  = t;
    return w;
  endfunction

  assign rd_data = show_status ? poll_word(op_is_prog, tgt_msb, tmo) : cell_word;
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import fos_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 6,
  parameter int TMO_LIMIT    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic              clr_cmd,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CNT_TOP = (TMO_LIMIT > DEPTH)
                         ? ((TMO_LIMIT > ERASE_CYCLES) ? TMO_LIMIT : ERASE_CYCLES)
                         : ((DEPTH > ERASE_CYCLES) ? DEPTH : ERASE_CYCLES);
  localparam int CNT_W   = $clog2(CNT_TOP + 1);
  localparam logic [CNT_W-1:0] PULSE_AT = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] TMO_AT   = CNT_W'(TMO_LIMIT - 1);
  localparam logic [CNT_W-1:0] WALK_END = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] ERS_END  = CNT_W'(ERASE_CYCLES - 1);

  function automatic logic [DATA_W-1:0] prog_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic verify_ok(input logic [DATA_W-1:0] stored,
                                     input logic [DATA_W-1:0] wanted);
    return stored == wanted;
  endfunction

  function automatic logic [DATA_W-1:0] damage_word(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w);
    logic [DATA_W-1:0] w;
    w    = prog_merge(old_w, new_w);
    w[0] = 1'b0;
    return w;
  endfunction

  fos_state_e        state_q, state_d;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [DATA_W-1:0] tgt_data_q;
  logic              tmo_q;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_clr;
  logic [DATA_W-1:0] cell_old, cell_rd, merged;

  // named internal events
  logic accept_prog, accept_erase, prog_pulse, prog_ok, prog_timeout;
  logic pre_walk, pre_last, erase_fill, abort_damage, op_is_prog, tmo_flag;
  logic wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  assign accept_prog  = (state_q == ST_IDLE) && start_prog;
  assign accept_erase = (state_q == ST_IDLE) && start_erase && !start_prog;
  assign merged       = prog_merge(cell_old, tgt_data_q);
  assign prog_ok      = verify_ok(merged, tgt_data_q);
  assign prog_pulse   = (state_q == ST_PROG) && (cnt == PULSE_AT) && rst_n;
  assign prog_timeout = (state_q == ST_PROG) && (cnt == TMO_AT);
  assign pre_walk     = (state_q == ST_PRE) && rst_n;
  assign pre_last     = (state_q == ST_PRE) && (cnt == WALK_END);
  assign erase_fill   = (state_q == ST_ERS) && (cnt == ERS_END) && rst_n;
  assign abort_damage = !rst_n && (state_q == ST_PROG);
  assign op_is_prog   = (state_q == ST_PROG) || (state_q == ST_FAIL);
  assign tmo_flag     = tmo_q;
  assign busy         = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_prog)       state_d = ST_PROG;
        else if (accept_erase) state_d = ST_PRE;
      end
      ST_PROG: begin
        if (prog_pulse && prog_ok) state_d = ST_IDLE;
        else if (prog_timeout)     state_d = ST_FAIL;
      end
      ST_PRE:  if (pre_last) state_d = ST_ERS;
      ST_ERS:  if (cnt == ERS_END) state_d = ST_IDLE;
      ST_FAIL: if (clr_cmd) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr = !rst_n || (state_d != state_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (prog_timeout && !(prog_pulse && prog_ok)) tmo_q <= 1'b1;
      else if (state_q == ST_FAIL && clr_cmd)       tmo_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept_prog && rst_n) begin
      tgt_addr_q <= op_addr;
      tgt_data_q <= op_data;
    end
  end

  // write source selection: reset damage, program pulse, erase walk
  always_comb begin
    wr_en   = abort_damage || prog_pulse || pre_walk;
    wr_addr = tgt_addr_q;
    wr_data = merged;
    if (abort_damage) begin
      wr_data = damage_word(cell_old, tgt_data_q);
    end else if (state_q == ST_PRE) begin
      wr_addr = cnt[ADDR_W-1:0];
      wr_data = '0;
    end
  end

  fos_step_counter #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .clr (cnt_clr),
    .cnt (cnt)
  );

  fos_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .fill_en  (erase_fill),
    .rd_addr  (rd_addr),
    .rd_word  (cell_rd),
    .tgt_addr (tgt_addr_q),
    .tgt_word (cell_old)
  );

  fos_poll_mux #(.DATA_W(DATA_W)) u_poll (
    .show_status (busy),
    .op_is_prog  (op_is_prog),
    .tmo         (tmo_q),
    .tgt_msb     (tgt_data_q[DATA_W-1]),
    .cell_word   (cell_rd),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/fos_checker.sv
module fos_checker #(
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_prog,
  input logic              start_erase,
  input logic              start_msb,
  input logic              clr_cmd,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              op_is_prog,
  input logic              tmo_flag,
  input logic              prog_pulse,
  input logic              pre_walk,
  input logic              pre_last,
  input logic              erase_fill
);
  logic        cap_msb;
  logic        walked;
  logic [15:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_msb  <= 1'b0;
      walked   <= 1'b0;
      busy_len <= '0;
    end else begin
      if (!busy && start_prog) cap_msb <= start_msb;
      if (!busy)               walked  <= 1'b0;
      else if (pre_last)       walked  <= 1'b1;
      if (!busy)                busy_len <= '0;
      else if (busy_len != '1) busy_len <= busy_len + 1'b1;
    end
  end

  assert_poll_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_is_prog) |-> (rd_data[DATA_W-1] == !cap_msb));

  assert_poll_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_is_prog) |-> (rd_data == '0));

  assert_tmo_shown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmo_flag) |-> rd_data[DATA_W-3]);

  assert_tmo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !clr_cmd) |=> tmo_flag);

  assert_prog_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> (busy_len == 16'(PROG_CYCLES - 1)));

  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_pulse, pre_walk, erase_fill}));

  assert_fill_after_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fill |-> walked);

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_prog && !start_erase) |=> !busy);
endmodule

bind flash_op_sequencer fos_checker #(.DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_fos_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_prog  (start_prog),
  .start_erase (start_erase),
  .start_msb   (op_data[DATA_W-1]),
  .clr_cmd     (clr_cmd),
  .rd_data     (rd_data),
  .busy        (busy),
  .op_is_prog  (op_is_prog),
  .tmo_flag    (tmo_flag),
  .prog_pulse  (prog_pulse),
  .pre_walk    (pre_walk),
  .pre_last    (pre_last),
  .erase_fill  (erase_fill)
);

// File: tb/flash_op_sequencer_bench.sv
`timescale 1ns/100ps
module flash_op_sequencer_bench;
  localparam int AW = 4, DW = 8, PC = 4, EC = 6, TL = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start_prog = 1'b0, start_erase = 1'b0, clr_cmd = 1'b0;
  logic [AW-1:0] op_addr = '0, rd_addr = '0;
  logic [DW-1:0] op_data = '0, rd_data;
  logic busy;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_op_sequencer #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC),
                       .ERASE_CYCLES(EC), .TMO_LIMIT(TL)) u_flash_op_sequencer (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .op_addr(op_addr), .op_data(op_data), .clr_cmd(clr_cmd), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy));

  // model arithmetic, restated
  function automatic logic [7:0] m_and(input logic [7:0] a, input logic [7:0] b);
    return ~(~a | ~b);
  endfunction
  function automatic logic [7:0] m_status(input logic prog, input logic msb, input logic t);
    return {prog & !msb, 1'b0, t, 5'b00000};
  endfunction

  typedef struct { string tag; logic [7:0] exp; } item_t;
  item_t sb[$];
  event rd_ev;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // driver side: push expectation, present address, trigger monitor
  task automatic exp_rd(input string tag, input logic [AW-1:0] a, input logic [7:0] v);
    item_t it;
    it.tag = tag; it.exp = v;
    sb.push_back(it);
    rd_addr = a;
    -> rd_ev;
    #0.8;
  endtask

  // monitor side
  initial begin
    forever begin
      item_t it;
      @(rd_ev);
      #0.4;
      it = sb.pop_front();
      chk(it.tag, {8'h00, rd_data}, {8'h00, it.exp});
    end
  end

  task automatic pulse_start(input bit erase, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    start_prog = !erase; start_erase = erase; op_addr = a; op_data = d;
    @(negedge clk);
    start_prog = 0; start_erase = 0;
  endtask

  task automatic wait_idle(inout int n);
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic hw_reset();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", {15'd0, busy}, 16'd0);

    // erase with mid-run status read and an ignored program request
    pulse_start(1, 0, 0);
    exp_rd("R7 erase status", 5, 8'h00);
    start_prog = 1; op_addr = 2; op_data = 8'h00;
    @(negedge clk);
    start_prog = 0;
    n = 1; wait_idle(n);
    chk("R7 erase busy length", 16'(n), 16'(DEPTH + EC));
    for (int i = 0; i < DEPTH; i++) exp_rd("R7 erased word", AW'(i), 8'hFF);
    exp_rd("R6 program ignored during erase", 2, 8'hFF);
    exp_rd("R1 idle read returns cell", 2, 8'hFF);

    // program sequence in mixed order
    pulse_start(0, 9, 8'hA5);
    exp_rd("R3 poll msb one", 0, m_status(1, 1'b1, 0));
    n = 0; wait_idle(n);
    chk("R2 program busy length", 16'(n), 16'(PC));
    pulse_start(0, 3, 8'h3C);
    exp_rd("R3 poll msb zero", 3, m_status(1, 1'b0, 0));
    n = 0; wait_idle(n);
    exp_rd("R2 stored word", 3, m_and(8'hFF, 8'h3C));
    pulse_start(0, 3, 8'h0C);
    n = 0; wait_idle(n);
    exp_rd("R2 reprogram clears bits", 3, 8'h0C);
    exp_rd("R2 other address", 9, 8'hA5);

    // zero-to-one attempt: timeout
    pulse_start(0, 3, 8'h34);
    repeat (TL - 1) @(negedge clk);
    exp_rd("R4 status before limit", 0, m_status(1, 1'b0, 0));
    @(negedge clk);
    exp_rd("R4 status at limit", 0, m_status(1, 1'b0, 1));
    repeat (5) @(negedge clk);
    exp_rd("R5 timeout sticky", 0, m_status(1, 1'b0, 1));
    chk("R5 still busy", {15'd0, busy}, 16'd1);
    clr_cmd = 1;
    @(negedge clk);
    clr_cmd = 0;
    chk("R5 clear leaves busy", {15'd0, busy}, 16'd0);
    exp_rd("R5 zero stays zero", 3, m_and(8'h0C, 8'h34));

    // commands during program are ignored
    pulse_start(0, 4, 8'h44);
    n = 0; wait_idle(n);
    pulse_start(0, 1, 8'h12);
    start_erase = 1; clr_cmd = 1; start_prog = 1; op_addr = 4; op_data = 8'h00;
    @(negedge clk);
    start_erase = 0; clr_cmd = 0; start_prog = 0;
    n = 1; wait_idle(n);
    chk("R6 program length unchanged", 16'(n), 16'(PC));
    exp_rd("R6 other cell untouched", 4, 8'h44);
    exp_rd("R6 target written", 1, 8'h12);

    // reset during program
    pulse_start(0, 7, 8'h77);
    @(negedge clk);
    hw_reset();
    chk("R9 busy after abort", {15'd0, busy}, 16'd0);
    exp_rd("R9 damaged cell", 7, m_and(8'hFF, 8'h77) & 8'hFE);

    // reset during zeroing walk after five addresses
    pulse_start(1, 0, 0);
    repeat (5) @(negedge clk);
    hw_reset();
    for (int i = 0; i < 5; i++) exp_rd("R8 walked cell zero", AW'(i), 8'h00);
    exp_rd("R8 unwalked cell kept", 9, 8'hA5);
    exp_rd("R8 unwalked cell kept", 7, 8'h76);
    exp_rd("R8 unwalked cell kept", 15, 8'hFF);

    // reset after walk, before fill
    pulse_start(1, 0, 0);
    repeat (DEPTH + 1) @(negedge clk);
    hw_reset();
    for (int i = 0; i < DEPTH; i++) exp_rd("R8 all zero before fill", AW'(i), 8'h00);

    pulse_start(1, 0, 0);
    n = 0; wait_idle(n);
    chk("R7 second erase length", 16'(n), 16'(DEPTH + EC));
    for (int i = 0; i < DEPTH; i++) exp_rd("R7 erased again", AW'(i), 8'hFF);

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule